// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a dot clock into the timing of a raster display. A dot counter splits each character cell into eight dots. A character counter steps once per cell and sets the horizontal position. A scanline counter steps once per line and sets the vertical position. In each axis six compare values set where the picture ends, where blanking starts and stops, where the sync pulse starts and stops, and how many steps make up the line or frame. From these compares the block decodes display-enable, a border (overscan) state, blank, hsync and vsync.

Software loads the compare values while the block runs. It writes one 16-bit word: the low byte selects a register and the high byte is the data to store. A protect bit in the control register stops writes to the timing registers. The block also drives two stored values straight out to neighbouring logic: a line pitch in character units for an external address generator, and the colour to show in the border. Pixel fetch, memory addressing, palette and analog output are handled outside this block.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset the dot, character and scanline counters are zero. The horizontal compares are total 100, display end 80, blank start 81, blank end 99, sync start 84 and sync end 96. The vertical compares are total 525, display end 480, blank start 487, blank end 516, sync start 489 and sync end 498. Pitch resets to 80 and border colour to 0.
- R2: The dot counter counts 0 to 7 and then wraps. The character counter changes only on a clock where the dot counter is 7.
- R3: At the end of a cell, the character counter clears to 0 if its value plus one is at least the horizontal total. In that case the scanline counter also steps, and it clears to 0 if its value plus one is at least the vertical total. Otherwise each counter adds one.
- R4: `disp_en_o` is high exactly when the character count is below the horizontal display end and the scanline count is below the vertical display end.
- R5: `blank_o` is high when the character count lies in [blank start, blank end) or the scanline count lies in [vertical blank start, vertical blank end).
- R6: `border_o` is high exactly when neither `disp_en_o` nor `blank_o` is high.
- R7: `hsync_o` is high when the character count lies in [sync start, sync end). `vsync_o` is high when the scanline count lies in [vertical sync start, vertical sync end). Both are active high.
- R8: A write stores data byte `reg_wdata_i[15:8]` into the register selected by `reg_wdata_i[7:0]`. The register map is:
  - Horizontal compares at 0x00..0x05, in the order total, display end, blank start, blank end, sync start, sync end.
  - Vertical compares, bits [7:0], at 0x06..0x0B in the same order.
  - Vertical compares, bits [9:8], at 0x0C..0x0E. Each of these holds two compares in the order above: the first in data bits [1:0] and the second in data bits [5:4].
  - Control at 0x11, pitch at 0x13 and border colour at 0x14.
  - Any other index is ignored.
- R9: While control bit 7 is set, writes to 0x00..0x0E are ignored. Control, pitch and colour stay writable at all times, and clearing bit 7 unlocks the timing registers.
- R10: A new compare value is used from the clock after it is written, even mid-frame. A counter already at or above a newly lowered total wraps to 0 at its next step.
- R11: `pitch_o` and `border_color_o` show the stored pitch and colour bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Write word: index in [7:0], data in [15:8] |
| disp_en_o | output | 1 | Active picture area |
| border_o | output | 1 | Overscan border area |
| blank_o | output | 1 | Blanking interval |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| dot_o | output | 3 | Dot position within the character cell |
| char_o | output | 8 | Character counter |
| line_o | output | 10 | Scanline counter |
| pitch_o | output | 8 | Line pitch in characters |
| border_color_o | output | 8 | Border colour |

## Verification
The assertions assume that reset is applied before the first clock. They also assume that the write strobe and write word carry no unknown bits once reset is released, because the lock and hold properties compare register state across a clock where a write may occur. The bench always drives both ports with fully defined values and changes them only at the falling clock edge. It keeps random totals small, so that lines and frames wrap many times within a run. It also sets some vertical totals above 255 so that the high-bit registers are used.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int DATA_W = 8;
  localparam int H_W    = 8;
  localparam int V_W    = 10;
  localparam int HI_W   = V_W - DATA_W;

  // compare slot order, shared by both axes
  localparam int CMP_TOTAL = 0;
  localparam int CMP_DE    = 1;
  localparam int CMP_BS    = 2;
  localparam int CMP_BE    = 3;
  localparam int CMP_SS    = 4;
  localparam int CMP_SE    = 5;
  localparam int NUM_CMP   = 6;

  localparam logic [DATA_W-1:0] IDX_H_BASE  = 8'h00;
  localparam logic [DATA_W-1:0] IDX_VLO     = 8'h06;
  localparam logic [DATA_W-1:0] IDX_VHI     = 8'h0C;
  localparam logic [DATA_W-1:0] IDX_TIM_END = 8'h0E;
  localparam logic [DATA_W-1:0] IDX_CTRL    = 8'h11;
  localparam logic [DATA_W-1:0] IDX_PITCH   = 8'h13;
  localparam logic [DATA_W-1:0] IDX_COLOR   = 8'h14;
  localparam int                LOCK_BIT    = 7;

  typedef logic [NUM_CMP-1:0][H_W-1:0] h_cmp_t;
  typedef logic [NUM_CMP-1:0][V_W-1:0] v_cmp_t;

  // slot [0] rightmost: total, de, bs, be, ss, se
  localparam h_cmp_t H_DEF = {8'd96, 8'd84, 8'd99, 8'd81, 8'd80, 8'd100};
  localparam v_cmp_t V_DEF = {10'd498, 10'd489, 10'd516, 10'd487, 10'd480, 10'd525};
  localparam logic [DATA_W-1:0] PITCH_DEF = 8'd80;
  localparam logic [DATA_W-1:0] COLOR_DEF = 8'd0;
endpackage

// File: rtl/crt_regs.sv
module crt_regs
  import crt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [15:0]       wdata_i,
  output h_cmp_t            h_cmp_o,
  output v_cmp_t            v_cmp_o,
  output logic [DATA_W-1:0] pitch_o,
  output logic [DATA_W-1:0] color_o
);
  logic [DATA_W-1:0] idx, dat;
  h_cmp_t            h_q;
  v_cmp_t            v_q;
  logic              lock_q;
  logic [DATA_W-1:0] pitch_q, color_q;
  logic              tim_wr;

  assign idx    = wdata_i[DATA_W-1:0];
  assign dat    = wdata_i[15:DATA_W];
  assign tim_wr = we_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q     <= H_DEF;
      v_q     <= V_DEF;
      lock_q  <= 1'b0;
      pitch_q <= PITCH_DEF;
      color_q <= COLOR_DEF;
    end else if (we_i) begin
      for (int k = 0; k < NUM_CMP; k++) begin
        if (tim_wr && idx == DATA_W'(IDX_H_BASE + k)) h_q[k] <= dat;
        if (tim_wr && idx == DATA_W'(IDX_VLO + k)) v_q[k][DATA_W-1:0] <= dat;
        // two high fields per byte: even slot in [1:0], odd slot in [5:4]
        if (tim_wr && idx == DATA_W'(IDX_VHI + k / 2))
          v_q[k][V_W-1:DATA_W] <= dat[(k % 2) * 4 +: HI_W];
      end
      if (idx == IDX_CTRL)  lock_q  <= dat[LOCK_BIT];
      if (idx == IDX_PITCH) pitch_q <= dat;
      if (idx == IDX_COLOR) color_q <= dat;
    end
  end

  assign h_cmp_o = h_q;
  assign v_cmp_o = v_q;
  assign pitch_o = pitch_q;
  assign color_o = color_q;

  p_lock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && we_i && idx <= IDX_TIM_END) |=> ($stable(h_q) && $stable(v_q)));
  p_ctrl_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == IDX_CTRL) |=> (lock_q == $past(dat[LOCK_BIT])));
  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(h_q) && $stable(v_q) && $stable(pitch_q) && $stable(color_q)));
endmodule

// File: rtl/crt_axis.sv
module crt_axis
  import crt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         adv_i,
  input  logic [NUM_CMP-1:0][W-1:0]    cmp_i,
  output logic [W-1:0]                 cnt_o,
  output logic                         wrap_o,
  output logic                         active_o,
  output logic                         blank_o,
  output logic                         sync_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;
  logic         at_end;

  assign nxt    = {1'b0, cnt_q} + (W+1)'(1);
  // >= so that a lowered total never lets the count run on
  assign at_end = nxt >= {1'b0, cmp_i[CMP_TOTAL]};
  assign wrap_o = adv_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= at_end ? '0 : nxt[W-1:0];
  end

  assign cnt_o    = cnt_q;
  assign active_o = cnt_q < cmp_i[CMP_DE];
  assign blank_o  = (cnt_q >= cmp_i[CMP_BS]) && (cnt_q < cmp_i[CMP_BE]);
  assign sync_o   = (cnt_q >= cmp_i[CMP_SS]) && (cnt_q < cmp_i[CMP_SE]);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_no_overrun_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && cnt_q >= cmp_i[CMP_TOTAL]) |=> (cnt_q == '0));
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
  import crt_pkg::*;
#(
  parameter int DOTS_PER_CHAR = 8,
  localparam int DOT_W = $clog2(DOTS_PER_CHAR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_wdata_i,
  output logic              disp_en_o,
  output logic              border_o,
  output logic              blank_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [DOT_W-1:0]  dot_o,
  output logic [H_W-1:0]    char_o,
  output logic [V_W-1:0]    line_o,
  output logic [DATA_W-1:0] pitch_o,
  output logic [DATA_W-1:0] border_color_o
);
  h_cmp_t           h_cmp;
  v_cmp_t           v_cmp;
  logic [DOT_W-1:0] dot_q;
  logic             dot_last;
  logic             h_wrap, v_wrap;
  logic             h_act, v_act, h_blank, v_blank;

  crt_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .h_cmp_o (h_cmp),
    .v_cmp_o (v_cmp),
    .pitch_o (pitch_o),
    .color_o (border_color_o)
  );

  assign dot_last = dot_q == DOT_W'(DOTS_PER_CHAR - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dot_q <= '0;
    else if (dot_last) dot_q <= '0;
    else               dot_q <= dot_q + DOT_W'(1);
  end

  crt_axis #(.W(H_W)) u_h_axis (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (dot_last),
    .cmp_i    (h_cmp),
    .cnt_o    (char_o),
    .wrap_o   (h_wrap),
    .active_o (h_act),
    .blank_o  (h_blank),
    .sync_o   (hsync_o)
  );

  crt_axis #(.W(V_W)) u_v_axis (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (h_wrap),
    .cmp_i    (v_cmp),
    .cnt_o    (line_o),
    .wrap_o   (v_wrap),
    .active_o (v_act),
    .blank_o  (v_blank),
    .sync_o   (vsync_o)
  );

  assign disp_en_o = h_act && v_act;
  assign blank_o   = h_blank || v_blank;
  assign border_o  = !disp_en_o && !blank_o;
  assign dot_o     = dot_q;

  p_dot_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_last |=> (dot_q == '0));
  p_dot_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_last |=> (dot_q == $past(dot_q) + DOT_W'(1)));
  p_char_cell_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_q != '0) |-> $stable(char_o));
  p_frame_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wrap |=> (line_o == '0 && char_o == '0));
endmodule

// File: tb/crt_timing_gen_bench.sv
module crt_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic        disp_en, border, blank, hsync, vsync;
  logic [2:0]  dot;
  logic [7:0]  chr;
  logic [9:0]  line;
  logic [7:0]  pitch, color;

  crt_timing_gen u_crt_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
    .disp_en_o(disp_en), .border_o(border), .blank_o(blank),
    .hsync_o(hsync), .vsync_o(vsync), .dot_o(dot), .char_o(chr),
    .line_o(line), .pitch_o(pitch), .border_color_o(color)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  // model state: slots total, de, bs, be, ss, se
  int m_h[6] = '{100, 80, 81, 99, 84, 96};
  int m_v[6] = '{525, 480, 487, 516, 489, 498};
  int m_lock = 0, m_pitch = 80, m_color = 0;
  int m_dot = 0, m_char = 0, m_line = 0;

  task automatic chk(string ph, string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s %s: actual %0d expected %0d", ph, tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(int c, int a, int b);
    return c >= a && c < b;
  endfunction

  task automatic check_all(string ph);
    bit e_de, e_bl;
    e_de = m_char < m_h[1] && m_line < m_v[1];
    e_bl = in_win(m_char, m_h[2], m_h[3]) || in_win(m_line, m_v[2], m_v[3]);
    chk(ph, "R2", "dot", int'(dot), m_dot);
    chk(ph, "R3", "char", int'(chr), m_char);
    chk(ph, "R3", "line", int'(line), m_line);
    chk(ph, "R4", "disp_en", int'(disp_en), int'(e_de));
    chk(ph, "R5", "blank", int'(blank), int'(e_bl));
    chk(ph, "R6", "border", int'(border), int'(!e_de && !e_bl));
    chk(ph, "R7", "hsync", int'(hsync), int'(in_win(m_char, m_h[4], m_h[5])));
    chk(ph, "R7", "vsync", int'(vsync), int'(in_win(m_line, m_v[4], m_v[5])));
    chk(ph, "R11", "pitch", int'(pitch), m_pitch);
    chk(ph, "R11", "color", int'(color), m_color);
  endtask

  task automatic model_adv();
    if (m_dot == 7) begin
      m_dot = 0;
      if (m_char + 1 >= m_h[0]) begin
        m_char = 0;
        if (m_line + 1 >= m_v[0]) m_line = 0;
        else m_line++;
      end else m_char++;
    end else m_dot++;
  endtask

  task automatic model_write(logic [15:0] w);
    int idx, d;
    idx = int'(w[7:0]);
    d = int'(w[15:8]);
    if (idx < 6) begin
      if (m_lock == 0) m_h[idx] = d;
    end else if (idx < 12) begin
      if (m_lock == 0) m_v[idx-6] = (m_v[idx-6] & 'h300) | d;
    end else if (idx < 15) begin
      if (m_lock == 0) begin
        m_v[2*(idx-12)]   = (m_v[2*(idx-12)] & 'hFF) | ((d & 3) << 8);
        m_v[2*(idx-12)+1] = (m_v[2*(idx-12)+1] & 'hFF) | (((d >> 4) & 3) << 8);
      end
    end else if (idx == 'h11) m_lock = (d >> 7) & 1;
    else if (idx == 'h13) m_pitch = d;
    else if (idx == 'h14) m_color = d;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(string ph, bit w, logic [15:0] data);
    we = w;
    wd = data;
    @(posedge clk);
    model_adv();
    if (w) model_write(data);
    @(negedge clk);
    we = 1'b0;
    check_all(ph);
  endtask

  task automatic run(string ph, int n);
    for (int i = 0; i < n; i++) step(ph, 1'b0, 16'h0);
  endtask

  task automatic prog(string ph, int idx, int val);
    step(ph, 1'b1, {8'(val), 8'(idx)});
  endtask

  task automatic prog_h(string ph, int t, int de, int bs, int be, int ss, int se);
    int v[6];
    v = '{t, de, bs, be, ss, se};
    for (int k = 0; k < 6; k++) prog(ph, k, v[k]);
  endtask

  task automatic prog_v(string ph, int t, int de, int bs, int be, int ss, int se);
    int v[6];
    v = '{t, de, bs, be, ss, se};
    for (int k = 0; k < 6; k++) prog(ph, 6 + k, v[k] & 'hFF);
    for (int p = 0; p < 3; p++)
      prog(ph, 12 + p, ((v[2*p] >> 8) & 3) | (((v[2*p+1] >> 8) & 3) << 4));
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % unsigned'(hi - lo + 1));
  endfunction

  initial begin
    int t;
    void'($urandom(32'h5eed_c0de));
    @(negedge clk);
    check_all("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");
    // one full default line plus a few cells
    run("R1", 820);

    // small frame: 12 chars x 10 lines
    prog_h("R8", 12, 8, 9, 11, 10, 11);
    prog_v("R8", 10, 6, 7, 9, 8, 9);
    run("R8", 2 * 12 * 8 * 10);
    // unmapped indices leave everything unchanged
    prog("R8", 'h0F, 'h03);
    prog("R8", 'h20, 'h02);
    run("R8", 200);

    // lock, then try to shrink the line
    prog("R9", 'h11, 'h80);
    prog("R9", 'h00, 5);
    prog("R9", 'h0C, 'h11);
    prog("R9", 'h13, 'h48);
    prog("R9", 'h14, 'h3C);
    run("R9", 300);
    prog("R9", 'h11, 'h00);
    prog("R9", 'h00, 5);
    run("R9", 300);
    prog("R9", 'h00, 12);

    // lower the total while the counter sits above it
    while (!(m_char >= 10 && m_dot == 3)) run("R10", 1);
    prog("R10", 'h00, 4);
    run("R10", 200);
    while (!(m_line >= 8 && m_dot == 2)) run("R10", 1);
    prog("R10", 'h06, 3);
    run("R10", 300);

    // random programming
    for (int it = 0; it < 30; it++) begin
      t = rnd(3, 16);
      prog_h("RND", t, rnd(0, t + 2), rnd(0, t + 2), rnd(0, t + 2),
             rnd(0, t + 2), rnd(0, t + 2));
      if (rnd(0, 3) == 0) t = rnd(256, 300);
      else t = rnd(2, 8);
      prog_v("RND", t, rnd(0, t + 2), rnd(0, t + 2), rnd(0, t + 2),
             rnd(0, t + 2), rnd(0, t + 2));
      if (rnd(0, 1) == 1) prog("RND", 'h14, rnd(0, 255));
      run("RND", 300);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule